// File: doc/BRIEF.md
# Receiver Reference-Voltage Search Controller

This block tunes the receive reference voltage of up to eight byte lanes, one 3-bit index per lane, so that each lane ends on the setting with the widest data eye. A lane whose window, measured before the search, is already wide enough is left alone. Every other lane starts at index 0. The controller then runs passes. In each pass it asks an external centering engine for three window measurements and keeps a running average per lane, in units of 1000 per measured tap. After the third measurement it moves each lane one step through its search. The search first climbs the index in coarse steps of 3. Once the window shrinks or the top index is reached, it walks back down in steps of 1 toward a recorded limit.

Each index change leaves the block as a write of that lane's control word. The low four bits carry a voltage code taken from a fixed non-linear index-to-code map. The upper bits are passed through unchanged from the lane's current control word. The search stops when every active lane has converged or after ten passes, whichever comes first, and `done_o` then pulses.

Both the measurement request and the response and code-write paths are valid/ready. A request stays asserted until it is accepted. The result is taken only in a cycle where both response valid and ready are high. A pending code write holds its lane and data stable for as long as the sink withholds ready.

Top module: `vref_search_fsm`

## Requirements
- R1: After reset `wr_valid_o`, `meas_req_valid_o`, `meas_rsp_ready_o` and `done_o` are all 0.
- R2: On start, a lane whose pre-measured window is greater than 12 is marked converged and is never written. A lane with a window of 12 or less starts at index 0 and is written once with the code for index 0. These initial writes go out in ascending lane order before the first measurement.
- R3: The code for index i is (i+1) mod 8, so indices 0..7 give codes 1,2,3,4,5,6,7,0. `wr_data_o[3:0]` holds this code, and `wr_data_o[7:4]` equals bits [7:4] of that lane's `lane_ctrl_i` word.
- R4: Each pass issues exactly three measurement requests. After measurement r (1..3), each unconverged lane's window becomes floor((window*(r-1) + 1000*result)/r), where the lane's 5-bit result occupies `meas_win_i[5*lane +: 5]`.
- R5: A lane is "not worse" when its averaged window plus 200 is at least its best recorded window. The best window is 0 at start.
- R6: Coarse lane, not worse: at index 7 the lane converges and is written with index 7. Otherwise the index becomes min(index+3, 7), the limit and the last index take the new value, and the lane becomes fine if the new index is 7. In both cases the best window becomes max(window, best) and the new index is written.
- R7: Coarse lane, worse: the lane becomes fine, with limit = index-3 (mod 8), best = window, last = index and index = index-1 (mod 8). The new index is written.
- R8: Fine lane, not worse: best = max(window, best) and last = index. If index-1 (mod 8) equals the limit, the index decrements and the lane converges. Else, if the index equals the limit, the lane converges. Otherwise the index decrements. The resulting index is written.
- R9: Fine lane, worse: the index returns to the last recorded index, the lane converges, and that index is written.
- R10: Before each pass the search ends if every active lane has converged or ten passes have run. `done_o` is then high for exactly one cycle.
- R11: `meas_req_valid_o` stays high until `meas_req_ready_i` is sampled high. Results are accepted only in a cycle with `meas_rsp_valid_i` and `meas_rsp_ready_o` both high.
- R12: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_lane_o` and `wr_data_o` hold their values. Each accepted write is counted once.
- R13: Only lanes below min(`lane_cnt_i`, 8) take part. Other lanes are never written and never block the search from ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a search when idle |
| lane_cnt_i | input | 4 | Number of active lanes (clamped to 8) |
| pre_win_i | input | 40 | Pre-measured window per lane, 5 bits each |
| lane_ctrl_i | input | 64 | Current control word per lane, 8 bits each |
| meas_req_valid_o | output | 1 | Measurement request valid |
| meas_req_ready_i | input | 1 | Centering engine accepts the request |
| meas_rsp_valid_i | input | 1 | Measurement result valid |
| meas_rsp_ready_o | output | 1 | Controller waits for a result |
| meas_win_i | input | 40 | Measured window per lane, 5 bits each |
| wr_valid_o | output | 1 | Control-word write valid |
| wr_ready_i | input | 1 | Write sink accepts the write |
| wr_lane_o | output | 3 | Lane of the pending write |
| wr_data_o | output | 8 | Control word: upper bits kept, low 4 bits the code |
| done_o | output | 1 | One-cycle pulse at the end of a search |

## Verification
The assertions assume that `lane_cnt_i`, `pre_win_i` and `lane_ctrl_i` stay constant from start until `done_o`, and that start is raised only while the controller is idle. The bench drives these three inputs once per run and pulses start only after it has seen the previous `done_o`. The bench also assumes the centering engine returns one result per accepted request. The bench's engine model keeps a count of outstanding requests and never offers a response without one. Request, response and write ready are randomised every cycle, so back-pressure hits both handshakes at arbitrary points.

// File: rtl/vref_search_pkg.sv
package vref_search_pkg;

  typedef enum logic [1:0] {
    LS_COARSE = 2'd0,
    LS_FINE   = 2'd1,
    LS_CONV   = 2'd2
  } lane_st_e;

  typedef enum logic [3:0] {
    T_IDLE, T_INIT, T_CHECK, T_REQ, T_WAIT,
    T_AVG, T_DIV, T_STEP, T_WR, T_DONE
  } top_st_e;

endpackage

// File: rtl/vref_avg_div.sv
// Restoring divider for a small divisor; one quotient bit per cycle.
module vref_avg_div #(
  parameter int N_W = 17,
  parameter int D_W = 2,
  parameter int Q_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N_W-1:0] dvd_i,
  input  logic [D_W-1:0] dsr_i,
  output logic [Q_W-1:0] quo_o,
  output logic           done_o
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   dvd_q;
  logic [D_W-1:0]   rem_q;
  logic [Q_W-1:0]   quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  logic [D_W:0] rem_s, rem_n;
  logic         bit_n;

  always_comb begin
    rem_s = {rem_q, dvd_q[N_W-1]};
    bit_n = (rem_s >= {1'b0, dsr_i});
    rem_n = bit_n ? (rem_s - {1'b0, dsr_i}) : rem_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      dvd_q  <= dvd_i;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= CNT_W'(N_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      dvd_q  <= dvd_q << 1;
      rem_q  <= rem_n[D_W-1:0];
      quo_q  <= {quo_q[Q_W-2:0], bit_n};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/vref_lane_step.sv
// One search step of a single lane, purely combinational.
module vref_lane_step
  import vref_search_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int WIN_W  = 15,
  parameter int COARSE = 3,
  parameter int FINE   = 1,
  parameter int MARGIN = 200
) (
  input  lane_st_e         st_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] lim_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [WIN_W-1:0] best_i,
  output lane_st_e         st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] lim_o,
  output logic [IDX_W-1:0] last_o,
  output logic [WIN_W-1:0] best_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] C_STEP  = IDX_W'(COARSE);
  localparam logic [IDX_W-1:0] F_STEP  = IDX_W'(FINE);

  logic [WIN_W:0]   padded;
  logic             not_worse;
  logic [IDX_W:0]   up_sum;
  logic [IDX_W-1:0] up_idx, dn_idx;
  logic [WIN_W-1:0] bigger;

  always_comb begin
    padded    = {1'b0, win_i} + (WIN_W+1)'(MARGIN);
    not_worse = padded >= {1'b0, best_i};
    up_sum    = {1'b0, idx_i} + {1'b0, C_STEP};
    up_idx    = (up_sum > {1'b0, IDX_TOP}) ? IDX_TOP : up_sum[IDX_W-1:0];
    dn_idx    = idx_i - F_STEP;
    bigger    = (win_i > best_i) ? win_i : best_i;

    st_o   = st_i;
    idx_o  = idx_i;
    lim_o  = lim_i;
    last_o = last_i;
    best_o = best_i;

    unique case (st_i)
      LS_COARSE: begin
        if (not_worse) begin
          best_o = bigger;
          if (idx_i == IDX_TOP) begin
            st_o = LS_CONV;
          end else begin
            idx_o  = up_idx;
            lim_o  = up_idx;
            last_o = up_idx;
            if (up_idx == IDX_TOP) st_o = LS_FINE;
          end
        end else begin
          st_o   = LS_FINE;
          lim_o  = idx_i - C_STEP;
          best_o = win_i;
          last_o = idx_i;
          idx_o  = dn_idx;
        end
      end
      LS_FINE: begin
        if (not_worse) begin
          best_o = bigger;
          last_o = idx_i;
          if (dn_idx == lim_i) begin
            idx_o = dn_idx;
            st_o  = LS_CONV;
          end else if (idx_i == lim_i) begin
            st_o = LS_CONV;
          end else begin
            idx_o = dn_idx;
          end
        end else begin
          idx_o = last_i;
          st_o  = LS_CONV;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vref_search_fsm.sv
module vref_search_fsm
  import vref_search_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int IDX_W    = 3,
  parameter int CODE_W   = 4,
  parameter int RES_W    = 5,
  parameter int PRE_W    = 5,
  parameter int CTRL_W   = 8,
  parameter int SKIP_TH  = 12,
  parameter int SCALE    = 1000,
  parameter int MARGIN   = 200,
  parameter int REPS     = 3,
  parameter int MAX_PASS = 10,
  parameter int COARSE   = 3,
  parameter int FINE     = 1,
  localparam int LANE_W  = $clog2(LANES),
  localparam int LCNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LCNT_W-1:0]       lane_cnt_i,
  input  logic [LANES*PRE_W-1:0]  pre_win_i,
  input  logic [LANES*CTRL_W-1:0] lane_ctrl_i,
  output logic                    meas_req_valid_o,
  input  logic                    meas_req_ready_i,
  input  logic                    meas_rsp_valid_i,
  output logic                    meas_rsp_ready_o,
  input  logic [LANES*RES_W-1:0]  meas_win_i,
  output logic                    wr_valid_o,
  input  logic                    wr_ready_i,
  output logic [LANE_W-1:0]       wr_lane_o,
  output logic [CTRL_W-1:0]       wr_data_o,
  output logic                    done_o
);
  localparam int WIN_W  = $clog2(SCALE * (2**RES_W - 1) + 1);
  localparam int REP_W  = $clog2(REPS + 1);
  localparam int SUM_W  = WIN_W + REP_W;
  localparam int PASS_W = $clog2(MAX_PASS + 1);

  // per-lane views of the flattened inputs
  logic [PRE_W-1:0]  pre_w  [LANES];
  logic [RES_W-1:0]  meas_w [LANES];
  logic [CTRL_W-1:0] ctrl_w [LANES];
  logic [LANES-1:0]  lane_open;

  top_st_e          state_q;
  lane_st_e         st_q   [LANES];
  logic [IDX_W-1:0] idx_q  [LANES];
  logic [IDX_W-1:0] lim_q  [LANES];
  logic [IDX_W-1:0] last_q [LANES];
  logic [WIN_W-1:0] win_q  [LANES];
  logic [WIN_W-1:0] best_q [LANES];
  logic [RES_W-1:0] res_q  [LANES];

  logic [LCNT_W-1:0] lane_q, lcnt_q;
  logic [REP_W-1:0]  rep_q;
  logic [PASS_W-1:0] pass_q;
  logic              in_init_q;
  logic [LANE_W-1:0] wr_lane_q;
  logic [CTRL_W-1:0] wr_data_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pre_w[g]     = pre_win_i[g*PRE_W +: PRE_W];
    assign meas_w[g]    = meas_win_i[g*RES_W +: RES_W];
    assign ctrl_w[g]    = lane_ctrl_i[g*CTRL_W +: CTRL_W];
    assign lane_open[g] = (LCNT_W'(g) < lcnt_q) && (st_q[g] != LS_CONV);
  end

  logic [LANE_W-1:0] li;
  logic              lanes_end, all_conv;
  assign li        = lane_q[LANE_W-1:0];
  assign lanes_end = (lane_q == lcnt_q);
  assign all_conv  = ~|lane_open;

  function automatic logic [CODE_W-1:0] code_of(input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] t;
    t = i + 1'b1;
    return CODE_W'(t);
  endfunction

  // running average: divide (win*(r-1) + SCALE*res) by r
  logic [SUM_W-1:0] div_dvd;
  logic [WIN_W-1:0] div_quo;
  logic             div_start, div_done;

  assign div_dvd   = SUM_W'(win_q[li]) * SUM_W'(rep_q - 1'b1)
                   + SUM_W'(SCALE) * SUM_W'(res_q[li]);
  assign div_start = (state_q == T_AVG) && !lanes_end && (st_q[li] != LS_CONV);

  vref_avg_div #(.N_W(SUM_W), .D_W(REP_W), .Q_W(WIN_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(div_start),
    .dvd_i  (div_dvd),
    .dsr_i  (rep_q),
    .quo_o  (div_quo),
    .done_o (div_done)
  );

  lane_st_e         nx_st;
  logic [IDX_W-1:0] nx_idx, nx_lim, nx_last;
  logic [WIN_W-1:0] nx_best;

  vref_lane_step #(
    .IDX_W(IDX_W), .WIN_W(WIN_W), .COARSE(COARSE), .FINE(FINE), .MARGIN(MARGIN)
  ) u_step (
    .st_i  (st_q[li]),
    .idx_i (idx_q[li]),
    .lim_i (lim_q[li]),
    .last_i(last_q[li]),
    .win_i (win_q[li]),
    .best_i(best_q[li]),
    .st_o  (nx_st),
    .idx_o (nx_idx),
    .lim_o (nx_lim),
    .last_o(nx_last),
    .best_o(nx_best)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= T_IDLE;
      lane_q    <= '0;
      lcnt_q    <= '0;
      rep_q     <= '0;
      pass_q    <= '0;
      in_init_q <= 1'b0;
      wr_lane_q <= '0;
      wr_data_q <= '0;
      for (int l = 0; l < LANES; l++) begin
        st_q[l]   <= LS_CONV;
        idx_q[l]  <= '0;
        lim_q[l]  <= '0;
        last_q[l] <= '0;
        win_q[l]  <= '0;
        best_q[l] <= '0;
        res_q[l]  <= '0;
      end
    end else begin
      unique case (state_q)
        T_IDLE: if (start_i) begin
          lcnt_q  <= (lane_cnt_i > LCNT_W'(LANES)) ? LCNT_W'(LANES) : lane_cnt_i;
          lane_q  <= '0;
          state_q <= T_INIT;
          for (int l = 0; l < LANES; l++) begin
            st_q[l]   <= LS_CONV;
            idx_q[l]  <= '0;
            lim_q[l]  <= '0;
            last_q[l] <= '0;
            win_q[l]  <= '0;
            best_q[l] <= '0;
          end
        end
        T_INIT: begin
          if (lanes_end) begin
            pass_q  <= '0;
            state_q <= T_CHECK;
          end else if (pre_w[li] > PRE_W'(SKIP_TH)) begin
            lane_q <= lane_q + 1'b1;
          end else begin
            st_q[li]  <= LS_COARSE;
            wr_lane_q <= li;
            wr_data_q <= {ctrl_w[li][CTRL_W-1:CODE_W], code_of('0)};
            in_init_q <= 1'b1;
            state_q   <= T_WR;
          end
        end
        T_CHECK: begin
          if (all_conv || pass_q == PASS_W'(MAX_PASS)) begin
            state_q <= T_DONE;
          end else begin
            rep_q   <= REP_W'(1);
            state_q <= T_REQ;
          end
        end
        T_REQ: if (meas_req_ready_i) state_q <= T_WAIT;
        T_WAIT: if (meas_rsp_valid_i) begin
          for (int l = 0; l < LANES; l++) res_q[l] <= meas_w[l];
          lane_q  <= '0;
          state_q <= T_AVG;
        end
        T_AVG: begin
          if (lanes_end) begin
            lane_q <= '0;
            if (rep_q == REP_W'(REPS)) begin
              state_q <= T_STEP;
            end else begin
              rep_q   <= rep_q + 1'b1;
              state_q <= T_REQ;
            end
          end else if (st_q[li] == LS_CONV) begin
            lane_q <= lane_q + 1'b1;
          end else begin
            state_q <= T_DIV;
          end
        end
        T_DIV: if (div_done) begin
          win_q[li] <= div_quo;
          lane_q    <= lane_q + 1'b1;
          state_q   <= T_AVG;
        end
        T_STEP: begin
          if (lanes_end) begin
            pass_q  <= pass_q + 1'b1;
            state_q <= T_CHECK;
          end else if (st_q[li] == LS_CONV) begin
            lane_q <= lane_q + 1'b1;
          end else begin
            st_q[li]   <= nx_st;
            idx_q[li]  <= nx_idx;
            lim_q[li]  <= nx_lim;
            last_q[li] <= nx_last;
            best_q[li] <= nx_best;
            wr_lane_q  <= li;
            wr_data_q  <= {ctrl_w[li][CTRL_W-1:CODE_W], code_of(nx_idx)};
            in_init_q  <= 1'b0;
            state_q    <= T_WR;
          end
        end
        T_WR: if (wr_ready_i) begin
          lane_q  <= lane_q + 1'b1;
          state_q <= in_init_q ? T_INIT : T_STEP;
        end
        T_DONE: state_q <= T_IDLE;
        default: state_q <= T_IDLE;
      endcase
    end
  end

  assign meas_req_valid_o = (state_q == T_REQ);
  assign meas_rsp_ready_o = (state_q == T_WAIT);
  assign wr_valid_o       = (state_q == T_WR);
  assign wr_lane_o        = wr_lane_q;
  assign wr_data_o        = wr_data_q;
  assign done_o           = (state_q == T_DONE);
endmodule

// File: rtl/vref_search_chk.sv
module vref_search_chk #(
  parameter int LANES    = 8,
  parameter int CODE_W   = 4,
  parameter int IDX_W    = 3,
  parameter int CTRL_W   = 8,
  parameter int REPS     = 3,
  parameter int MAX_PASS = 10,
  localparam int LANE_W  = $clog2(LANES),
  localparam int LCNT_W  = $clog2(LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LCNT_W-1:0]       lane_cnt_i,
  input logic [LANES*CTRL_W-1:0] lane_ctrl_i,
  input logic                    meas_req_valid_o,
  input logic                    meas_req_ready_i,
  input logic                    wr_valid_o,
  input logic                    wr_ready_i,
  input logic [LANE_W-1:0]       wr_lane_o,
  input logic [CTRL_W-1:0]       wr_data_o,
  input logic                    done_o
);
  localparam int REQ_LIMIT = REPS * MAX_PASS;
  localparam int RC_W      = $clog2(REQ_LIMIT + 2);

  logic [RC_W-1:0] req_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_cnt <= '0;
    else if (done_o) req_cnt <= '0;
    else if (meas_req_valid_o && meas_req_ready_i) req_cnt <= req_cnt + 1'b1;
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid_o && !meas_req_ready_i |=> meas_req_valid_o);

  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_lane_o) && $stable(wr_data_o));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_pass_limit: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= RC_W'(REQ_LIMIT));

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_data_o[CTRL_W-1:CODE_W]
                   == lane_ctrl_i[int'(wr_lane_o)*CTRL_W + CODE_W +: CTRL_W-CODE_W]);

  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_data_o[CODE_W-1:0] < CODE_W'(2**IDX_W));

  a_r13_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> LCNT_W'(wr_lane_o) < lane_cnt_i);

  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid_o && meas_req_valid_o));
endmodule

bind vref_search_fsm vref_search_chk #(
  .LANES(LANES), .CODE_W(CODE_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W),
  .REPS(REPS), .MAX_PASS(MAX_PASS)
) u_chk (.*);

// File: tb/vref_search_fsm_bench.sv
module vref_search_fsm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  lane_cnt_i = '0;
  logic [39:0] pre_win_i = '0;
  logic [63:0] lane_ctrl_i = '0;
  logic        meas_req_valid_o, meas_req_ready_i = 1'b0;
  logic        meas_rsp_valid_i = 1'b0, meas_rsp_ready_o;
  logic [39:0] meas_win_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b0;
  logic [2:0]  wr_lane_o;
  logic [7:0]  wr_data_o;
  logic        done_o;

  vref_search_fsm u_vref_search_fsm (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int res_tab [30][8];
  int pre_a [8], ctrl_a [8];
  int lcnt;
  int exp_lane [128], exp_data [128], exp_tag [128];
  int exp_n, exp_meas;
  int got_lane [128], got_data [128];
  int got_n, got_meas;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      2: return "R2 R3 init write";
      6: return "R5 R6 coarse not-worse";
      7: return "R5 R7 coarse worse";
      8: return "R5 R8 fine not-worse";
      default: return "R9 fine worse";
    endcase
  endfunction

  task automatic emit(input int l, input int idx, input int tag);
    exp_lane[exp_n] = l;
    exp_data[exp_n] = (ctrl_a[l] & 'hF0) | ((idx + 1) % 8);  // R3 map
    exp_tag[exp_n]  = tag;
    exp_n++;
  endtask

  // Reference search computed from the requirements.
  task automatic model_run();
    int st[8], idx[8], lim[8], last[8], win[8], best[8];
    int n;
    n = (lcnt > 8) ? 8 : lcnt;
    exp_n = 0; exp_meas = 0;
    for (int l = 0; l < 8; l++) begin
      st[l] = 2; idx[l] = 0; lim[l] = 0; last[l] = 0; win[l] = 0; best[l] = 0;
    end
    for (int l = 0; l < n; l++)
      if (pre_a[l] <= 12) begin st[l] = 0; emit(l, 0, 2); end
    for (int p = 0; p < 10; p++) begin
      bit open;
      open = 0;
      for (int l = 0; l < n; l++) if (st[l] != 2) open = 1;
      if (!open) break;
      for (int r = 1; r <= 3; r++) begin
        for (int l = 0; l < n; l++)
          if (st[l] != 2) win[l] = (win[l] * (r - 1) + 1000 * res_tab[exp_meas][l]) / r;
        exp_meas++;
      end
      for (int l = 0; l < n; l++) begin
        bit nw;
        int mx;
        if (st[l] == 2) continue;
        nw = (win[l] + 200 >= best[l]);  // R5 margin
        mx = (win[l] > best[l]) ? win[l] : best[l];
        if (st[l] == 0) begin
          if (nw) begin
            best[l] = mx;
            if (idx[l] == 7) st[l] = 2;
            else begin
              idx[l] = (idx[l] + 3 > 7) ? 7 : idx[l] + 3;
              lim[l] = idx[l]; last[l] = idx[l];
              if (idx[l] == 7) st[l] = 1;
            end
            emit(l, idx[l], 6);
          end else begin
            st[l] = 1; lim[l] = (idx[l] - 3) & 7; best[l] = win[l];
            last[l] = idx[l]; idx[l] = (idx[l] - 1) & 7;
            emit(l, idx[l], 7);
          end
        end else begin
          if (nw) begin
            best[l] = mx; last[l] = idx[l];
            if (((idx[l] - 1) & 7) == lim[l]) begin idx[l] = (idx[l] - 1) & 7; st[l] = 2; end
            else if (idx[l] == lim[l]) st[l] = 2;
            else idx[l] = (idx[l] - 1) & 7;
            emit(l, idx[l], 8);
          end else begin
            idx[l] = last[l]; st[l] = 2;
            emit(l, idx[l], 9);
          end
        end
      end
    end
  endtask

  task automatic fill(input int mode, input int v);
    int walk[8];
    for (int l = 0; l < 8; l++) walk[l] = 8 + $urandom % 16;
    for (int m = 0; m < 30; m++)
      for (int l = 0; l < 8; l++) begin
        case (mode)
          0: res_tab[m][l] = v;
          1: res_tab[m][l] = $urandom % 32;
          2: begin
            walk[l] = walk[l] + int'($urandom % 5) - 2;
            if (walk[l] < 0) walk[l] = 0;
            if (walk[l] > 31) walk[l] = 31;
            res_tab[m][l] = walk[l];
          end
          default: res_tab[m][l] = (31 - m - l > 0) ? 31 - m - l : 0;
        endcase
      end
  endtask

  task automatic run_test();
    int pend, cyc;
    bit seen_done, bad_lane;
    for (int l = 0; l < 8; l++) begin
      pre_win_i[l*5 +: 5]   = 5'(pre_a[l]);
      lane_ctrl_i[l*8 +: 8] = 8'(ctrl_a[l]);
    end
    lane_cnt_i = 4'(lcnt);
    model_run();
    got_n = 0; got_meas = 0; pend = 0; seen_done = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (done_o) begin seen_done = 1; break; end
      meas_req_ready_i = meas_req_valid_o && ($urandom % 3 != 0);
      if (meas_req_ready_i) pend++;
      if (meas_rsp_ready_o && pend > 0 && got_meas < 30 && ($urandom % 2 == 0)) begin
        meas_rsp_valid_i = 1'b1;
        for (int l = 0; l < 8; l++) meas_win_i[l*5 +: 5] = 5'(res_tab[got_meas][l]);
        got_meas++; pend--;
      end else begin
        meas_rsp_valid_i = 1'b0;
        meas_win_i = 40'($urandom) ^ {8'($urandom), 32'($urandom)};
      end
      wr_ready_i = wr_valid_o && ($urandom % 3 != 0);
      if (wr_ready_i && got_n < 128) begin
        got_lane[got_n] = int'(wr_lane_o);
        got_data[got_n] = int'(wr_data_o);
        got_n++;
      end
    end
    meas_req_ready_i = 0; meas_rsp_valid_i = 0; wr_ready_i = 0;
    if (!seen_done) begin
      chk(0, "R10 watchdog: done never seen", cyc, 1);
      rst_n = 0; @(negedge clk); rst_n = 1;
      return;
    end
    chk(1, "R10 done", 1, 1);
    chk(got_meas == exp_meas, "R4 R11 measurement count", got_meas, exp_meas);
    chk(got_n == exp_n, "R10 R12 write count", got_n, exp_n);
    bad_lane = 0;
    for (int i = 0; i < got_n; i++) if (got_lane[i] >= ((lcnt > 8) ? 8 : lcnt)) bad_lane = 1;
    chk(!bad_lane, "R13 lanes beyond count untouched", bad_lane, 0);
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      chk(got_lane[i] == exp_lane[i], tag_name(exp_tag[i]), got_lane[i], exp_lane[i]);
      chk(got_data[i] == exp_data[i], tag_name(exp_tag[i]), got_data[i], exp_data[i]);
    end
  endtask

  task automatic set_lanes(input int n, input int pre_fixed, input bit rnd);
    lcnt = n;
    for (int l = 0; l < 8; l++) begin
      pre_a[l]  = rnd ? int'($urandom % 21) : pre_fixed;
      ctrl_a[l] = int'($urandom % 256);
    end
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!wr_valid_o && !meas_req_valid_o && !meas_rsp_ready_o && !done_o,
        "R1 idle after reset",
        {wr_valid_o, meas_req_valid_o, meas_rsp_ready_o, done_o}, 0);

    // R2: all lanes above threshold -> no writes, no measurement
    set_lanes(8, 13, 0); fill(0, 10); run_test();
    // R2 boundary: window 12 still searched; constant result climbs to the top
    set_lanes(1, 12, 0); fill(0, 20); run_test();
    // R13: zero lanes and an over-range count
    set_lanes(0, 0, 0); fill(1, 0); run_test();
    set_lanes(15, 0, 0); fill(2, 0); run_test();
    // R7 R9: steadily shrinking windows
    set_lanes(4, 0, 0); fill(3, 0); run_test();
    // random mixes
    for (int t = 0; t < 8; t++) begin
      set_lanes(1 + int'($urandom % 8), 0, 1);
      fill((t % 2 == 0) ? 2 : 1, 0);
      run_test();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_err++; n_chk++;
    $display("FAIL R10 global watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule